// File: doc/BRIEF.md
# Segment Selector Load Checker

This block decides whether a selector may be loaded into one of the data or stack segment registers. The caller presents the target register, the 16-bit selector, the current privilege level, the operating mode, the byte limit of the descriptor table that the selector refers to, and the decoded fields of the descriptor the selector names. One cycle later the block reports either a commit, which carries the selector to be written, or a single fault, which carries a fault kind and an error code.

Fetching the descriptor from memory is done elsewhere. The descriptor fields arrive already decoded. The caller picks the table limit, and the selector's table-indicator bit passes through untouched. Each register class has its own rule set. The stack register refuses a null selector and demands exact privilege equality. The four data registers accept a null selector and use a combined privilege test. In 64-bit mode only the two extra data registers can be loaded at all.

Top module: `seg_load_chk`

## Requirements
- R1: While reset is held, and in the first cycle after it, commit_o and fault_o are both 0.
- R2: The outcome of a request appears exactly one cycle after req_valid is sampled high. A cycle with req_valid low gives commit_o=0, fault_o=0, fault_kind=0, err_code=0 and commit_sel=0 in the cycle that follows.
- R3: Target codes are 0=stack, 1..4=data registers (1 and 2 are the legacy pair, 3 and 4 are the extra pair). A selector whose bits 15:2 are all zero is null. A null selector for any data register commits, with commit_sel equal to the selector and no fault.
- R4: Fault kinds are 1=general protection, 2=not present, 3=stack fault and 4=invalid load. A null selector for the stack register gives kind 1 with err_code 0.
- R5: For a non-null stack load, kind 1 with err_code equal to the selector is reported if any of these holds: RPL (selector bits 1:0) differs from CPL, DPL differs from CPL, or the descriptor is not a writable data segment. A writable data segment has desc_cd=1, desc_type bit 3 = 0 and desc_type bit 1 = 1.
- R6: A stack load that passes every R5 and R9 check but has desc_present=0 gives kind 3 with err_code equal to the selector.
- R7: For a non-null data-register load, kind 1 with err_code equal to the selector is reported if either of these holds. First, the descriptor is neither data nor readable code: desc_cd=0, or desc_type bit 3 = 1 with bit 1 = 0. Second, the segment is data or nonconforming code (code with desc_type bit 2 = 0), and both RPL and CPL are numerically greater than DPL.
- R8: A data-register load that passes every R7 and R9 check but has desc_present=0 gives kind 2 with err_code equal to the selector.
- R9: For any non-null load, a selector whose value {index,3'b111} (index*8+7) exceeds tbl_limit gives kind 1 with err_code equal to the selector.
- R10: With long_mode=1, loads to targets 0, 1 and 2 give kind 4 with err_code 0. Targets 3 and 4 follow R3, R7, R8 and R9.
- R11: Privilege, type and limit faults take priority over the present check. commit_o and fault_o are never high together, and on a commit err_code is 0.
- R12: Target codes 5..7 give kind 4 with err_code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A load request is present this cycle |
| req_target | input | 3 | Target register code |
| req_sel | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = protected/compatibility |
| tbl_limit | input | 16 | Byte limit of the selected descriptor table |
| desc_cd | input | 1 | Descriptor is a code/data segment (not system) |
| desc_type | input | 4 | Descriptor type field |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present bit |
| commit_o | output | 1 | The load succeeded |
| commit_sel | output | 16 | Selector to write on commit, else 0 |
| fault_o | output | 1 | The load faulted |
| fault_kind | output | 3 | Fault kind code, 0 when no fault |
| err_code | output | 16 | Error code of the fault |

## Verification
The assertions take the descriptor fields to be stable and meaningful only in the cycle in which req_valid is high. They also assume that nothing on the inputs links one request to the next, so every property ties a single sampled request to the following cycle's output. The stimulus keeps to this by driving every request field together on the falling edge and dropping req_valid between groups. The table limit is always given as a full byte limit. Selectors are chosen so that each case trips exactly one rule, or a deliberate pair of rules to exercise priority, with the other fields held at passing values.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [2:0] {
        TGT_STK = 3'd0,
        TGT_D0  = 3'd1,
        TGT_D1  = 3'd2,
        TGT_X0  = 3'd3,
        TGT_X1  = 3'd4
    } seg_tgt_e;

    typedef enum logic [2:0] {
        FK_NONE = 3'd0,
        FK_GP   = 3'd1,
        FK_NP   = 3'd2,
        FK_STK  = 3'd3,
        FK_INV  = 3'd4
    } fault_kind_e;

    // ok: commit; use_sel: the error code carries the selector
    typedef struct packed {
        logic        ok;
        fault_kind_e kind;
        logic        use_sel;
    } verdict_t;

    // descriptor type field bit positions
    localparam int TB_CODE = 3;
    localparam int TB_CONF = 2;
    localparam int TB_RW   = 1;

endpackage

// File: rtl/seg_bound_chk.sv
module seg_bound_chk #(
    parameter int SELW = 16,
    parameter int LIMW = 16
) (
    input  logic [SELW-1:0] sel,
    input  logic [LIMW-1:0] limit,
    output logic            in_bounds
);
    localparam int CW = (SELW > LIMW) ? SELW : LIMW;

    logic [CW-1:0] last_byte;
    logic [CW-1:0] lim_ext;

    always_comb begin
        last_byte = '0;
        last_byte[SELW-1:0] = {sel[SELW-1:3], 3'b111};
        lim_ext = '0;
        lim_ext[LIMW-1:0] = limit;
        in_bounds = (last_byte <= lim_ext);
    end
endmodule

// File: rtl/seg_stack_rules.sv
module seg_stack_rules
    import seg_chk_pkg::*;
(
    input  logic       is_null,
    input  logic       in_bounds,
    input  logic [1:0] rpl,
    input  logic [1:0] cpl,
    input  logic       desc_cd,
    input  logic [3:0] desc_type,
    input  logic [1:0] desc_dpl,
    input  logic       desc_present,
    output verdict_t   verdict
);
    logic wr_data;
    logic gp_hit;

    always_comb begin
        wr_data = desc_cd && !desc_type[TB_CODE] && desc_type[TB_RW];
        gp_hit  = !in_bounds || (rpl != cpl) || !wr_data || (desc_dpl != cpl);
        verdict = '{ok: 1'b0, kind: FK_NONE, use_sel: 1'b0};
        if (is_null) begin
            verdict.kind = FK_GP;
        end else if (gp_hit) begin
            verdict.kind    = FK_GP;
            verdict.use_sel = 1'b1;
        end else if (!desc_present) begin
            verdict.kind    = FK_STK;
            verdict.use_sel = 1'b1;
        end else begin
            verdict.ok = 1'b1;
        end
    end
endmodule

// File: rtl/seg_data_rules.sv
module seg_data_rules
    import seg_chk_pkg::*;
(
    input  logic       is_null,
    input  logic       in_bounds,
    input  logic [1:0] rpl,
    input  logic [1:0] cpl,
    input  logic       desc_cd,
    input  logic [3:0] desc_type,
    input  logic [1:0] desc_dpl,
    input  logic       desc_present,
    output verdict_t   verdict
);
    logic readable;
    logic priv_checked;
    logic priv_bad;
    logic gp_hit;

    always_comb begin
        readable     = desc_cd && (!desc_type[TB_CODE] || desc_type[TB_RW]);
        priv_checked = !desc_type[TB_CODE] || !desc_type[TB_CONF];
        priv_bad     = priv_checked && (rpl > desc_dpl) && (cpl > desc_dpl);
        gp_hit       = !in_bounds || !readable || priv_bad;
        verdict = '{ok: 1'b0, kind: FK_NONE, use_sel: 1'b0};
        if (is_null) begin
            verdict.ok = 1'b1;
        end else if (gp_hit) begin
            verdict.kind    = FK_GP;
            verdict.use_sel = 1'b1;
        end else if (!desc_present) begin
            verdict.kind    = FK_NP;
            verdict.use_sel = 1'b1;
        end else begin
            verdict.ok = 1'b1;
        end
    end
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk
    import seg_chk_pkg::*;
#(
    parameter int SELW = 16,
    parameter int LIMW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_target,
    input  logic [SELW-1:0] req_sel,
    input  logic [1:0]      cpl,
    input  logic            long_mode,
    input  logic [LIMW-1:0] tbl_limit,
    input  logic            desc_cd,
    input  logic [3:0]      desc_type,
    input  logic [1:0]      desc_dpl,
    input  logic            desc_present,
    output logic            commit_o,
    output logic [SELW-1:0] commit_sel,
    output logic            fault_o,
    output logic [2:0]      fault_kind,
    output logic [SELW-1:0] err_code
);
    typedef struct packed {
        logic            commit;
        logic [SELW-1:0] csel;
        logic            fault;
        fault_kind_e     kind;
        logic [SELW-1:0] err;
    } out_t;

    out_t state_d, state_q;

    logic     sel_null;
    logic     sel_in_bounds;
    verdict_t stk_v, dat_v;

    assign sel_null = (req_sel[SELW-1:2] == '0);

    seg_bound_chk #(.SELW(SELW), .LIMW(LIMW)) u_bound (
        .sel       (req_sel),
        .limit     (tbl_limit),
        .in_bounds (sel_in_bounds)
    );

    seg_stack_rules u_stk (
        .is_null      (sel_null),
        .in_bounds    (sel_in_bounds),
        .rpl          (req_sel[1:0]),
        .cpl          (cpl),
        .desc_cd      (desc_cd),
        .desc_type    (desc_type),
        .desc_dpl     (desc_dpl),
        .desc_present (desc_present),
        .verdict      (stk_v)
    );

    seg_data_rules u_dat (
        .is_null      (sel_null),
        .in_bounds    (sel_in_bounds),
        .rpl          (req_sel[1:0]),
        .cpl          (cpl),
        .desc_cd      (desc_cd),
        .desc_type    (desc_type),
        .desc_dpl     (desc_dpl),
        .desc_present (desc_present),
        .verdict      (dat_v)
    );

    always_comb begin
        verdict_t pick;
        logic     invalid;
        state_d = '0;
        invalid = 1'b0;
        pick    = dat_v;
        case (req_target)
            TGT_STK: begin
                pick    = stk_v;
                invalid = long_mode;
            end
            TGT_D0, TGT_D1: invalid = long_mode;
            TGT_X0, TGT_X1: invalid = 1'b0;
            default:        invalid = 1'b1;
        endcase
        if (req_valid) begin
            if (invalid) begin
                state_d.fault = 1'b1;
                state_d.kind  = FK_INV;
            end else if (pick.ok) begin
                state_d.commit = 1'b1;
                state_d.csel   = req_sel;
            end else begin
                state_d.fault = 1'b1;
                state_d.kind  = pick.kind;
                state_d.err   = pick.use_sel ? req_sel : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign commit_o   = state_q.commit;
    assign commit_sel = state_q.csel;
    assign fault_o    = state_q.fault;
    assign fault_kind = state_q.kind;
    assign err_code   = state_q.err;

    // R11
    exclusive_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && fault_o));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!commit_o && !fault_o));

    // R4
    null_stack_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_target == 3'd0 && !long_mode && req_sel[SELW-1:2] == '0)
        |=> (fault_o && fault_kind == 3'd1 && err_code == '0));

    // R3
    null_data_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_target == 3'd3 || req_target == 3'd4) && req_sel[SELW-1:2] == '0)
        |=> (commit_o && commit_sel == $past(req_sel)));

    // R10
    long_mode_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && long_mode && req_target <= 3'd2)
        |=> (fault_o && fault_kind == 3'd4 && err_code == '0));

    // R11
    commit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> (err_code == '0 && fault_kind == 3'd0));

endmodule

// File: tb/seg_load_chk_bench.sv
module seg_load_chk_bench;

    typedef struct {
        logic        c;
        logic        f;
        logic [2:0]  k;
        logic [15:0] e;
        logic [15:0] s;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_target = '0;
    logic [15:0] req_sel = '0;
    logic [1:0]  cpl = '0;
    logic        long_mode = 1'b0;
    logic [15:0] tbl_limit = '0;
    logic        desc_cd = 1'b0;
    logic [3:0]  desc_type = '0;
    logic [1:0]  desc_dpl = '0;
    logic        desc_present = 1'b0;
    logic        commit_o;
    logic [15:0] commit_sel;
    logic        fault_o;
    logic [2:0]  fault_kind;
    logic [15:0] err_code;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    seg_load_chk u_seg_load_chk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
        .req_sel(req_sel), .cpl(cpl), .long_mode(long_mode), .tbl_limit(tbl_limit),
        .desc_cd(desc_cd), .desc_type(desc_type), .desc_dpl(desc_dpl),
        .desc_present(desc_present), .commit_o(commit_o), .commit_sel(commit_sel),
        .fault_o(fault_o), .fault_kind(fault_kind), .err_code(err_code)
    );

    function automatic exp_t predict(input logic [2:0] t, input logic [15:0] s,
        input logic [1:0] pl, input logic lm, input logic [15:0] lim, input logic cd,
        input logic [3:0] ty, input logic [1:0] dp, input logic pr, input string tag);
        exp_t x;
        logic nul, oob, gp;
        logic [16:0] last;
        x = '{c: 1'b0, f: 1'b0, k: 3'd0, e: 16'd0, s: 16'd0, tag: tag};
        nul  = (s[15:2] == 14'd0);
        last = {1'b0, s[15:3], 3'b111};
        oob  = last > {1'b0, lim};
        if (t > 3'd4 || (lm && t <= 3'd2)) begin
            x.f = 1'b1; x.k = 3'd4;
        end else if (t == 3'd0) begin
            gp = oob || s[1:0] != pl || dp != pl || !(cd && !ty[3] && ty[1]);
            if (nul) begin x.f = 1'b1; x.k = 3'd1; end
            else if (gp) begin x.f = 1'b1; x.k = 3'd1; x.e = s; end
            else if (!pr) begin x.f = 1'b1; x.k = 3'd3; x.e = s; end
            else begin x.c = 1'b1; x.s = s; end
        end else begin
            gp = oob || !cd || (ty[3] && !ty[1]) ||
                 ((!ty[3] || !ty[2]) && s[1:0] > dp && pl > dp);
            if (nul) begin x.c = 1'b1; x.s = s; end
            else if (gp) begin x.f = 1'b1; x.k = 3'd1; x.e = s; end
            else if (!pr) begin x.f = 1'b1; x.k = 3'd2; x.e = s; end
            else begin x.c = 1'b1; x.s = s; end
        end
        return x;
    endfunction

    task automatic send(input logic [2:0] t, input logic [15:0] s, input logic [1:0] pl,
        input logic lm, input logic [15:0] lim, input logic cd, input logic [3:0] ty,
        input logic [1:0] dp, input logic pr, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_target = t; req_sel = s; cpl = pl; long_mode = lm;
        tbl_limit = lim; desc_cd = cd; desc_type = ty; desc_dpl = dp; desc_present = pr;
        sb.push_back(predict(t, s, pl, lm, lim, cd, ty, dp, pr, tag));
    endtask

    task automatic idle(input string tag);
        exp_t x;
        @(negedge clk);
        req_valid = 1'b0;
        x = '{c: 1'b0, f: 1'b0, k: 3'd0, e: 16'd0, s: 16'd0, tag: tag};
        sb.push_back(x);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t x;
            x = sb.pop_front();
            n_checks++;
            if (commit_o !== x.c || fault_o !== x.f || fault_kind !== x.k ||
                err_code !== x.e || commit_sel !== x.s) begin
                n_fail++;
                $display("FAIL %s: got c=%b f=%b k=%0d e=%h s=%h, want c=%b f=%b k=%0d e=%h s=%h",
                    x.tag, commit_o, fault_o, fault_kind, err_code, commit_sel,
                    x.c, x.f, x.k, x.e, x.s);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got hung run, want completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: outputs during reset
        repeat (3) @(negedge clk);
        n_checks++;
        if (commit_o !== 1'b0 || fault_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got c=%b f=%b, want c=0 f=0", commit_o, fault_o);
        end
        rst_n = 1'b1;
        idle("R1");
        idle("R2");

        // R3: null into data registers, any RPL
        send(3'd1, 16'h0000, 2'd0, 1'b0, 16'h00FF, 1'b0, 4'h0, 2'd0, 1'b0, "R3");
        send(3'd2, 16'h0003, 2'd3, 1'b0, 16'h00FF, 1'b0, 4'h0, 2'd0, 1'b0, "R3");
        send(3'd4, 16'h0002, 2'd1, 1'b1, 16'h0000, 1'b0, 4'h0, 2'd0, 1'b0, "R3");
        // R4: null into stack
        send(3'd0, 16'h0001, 2'd1, 1'b0, 16'h00FF, 1'b1, 4'h2, 2'd1, 1'b1, "R4");
        idle("R2");
        // stack: good commit, then each GP cause
        send(3'd0, 16'h0010, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b1, "R5");
        send(3'd0, 16'h0011, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b1, "R5");
        send(3'd0, 16'h0013, 2'd3, 1'b0, 16'h00FF, 1'b1, 4'h2, 2'd1, 1'b1, "R5");
        send(3'd0, 16'h0010, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h0, 2'd0, 1'b1, "R5");
        send(3'd0, 16'h0010, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'hA, 2'd0, 1'b1, "R5");
        send(3'd0, 16'h0010, 2'd0, 1'b0, 16'h00FF, 1'b0, 4'h2, 2'd0, 1'b1, "R5");
        // R6: not present stack; R11: GP wins over not present
        send(3'd0, 16'h0022, 2'd2, 1'b0, 16'h00FF, 1'b1, 4'h3, 2'd2, 1'b0, "R6");
        send(3'd0, 16'h0022, 2'd1, 1'b0, 16'h00FF, 1'b1, 4'h3, 2'd2, 1'b0, "R11");
        idle("R2");
        // data GP causes
        send(3'd1, 16'h0028, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h0, 2'd3, 1'b1, "R7");
        send(3'd2, 16'h0028, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h8, 2'd0, 1'b1, "R7");
        send(3'd3, 16'h002B, 2'd3, 1'b0, 16'h00FF, 1'b1, 4'h2, 2'd1, 1'b1, "R7");
        send(3'd3, 16'h002B, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h2, 2'd1, 1'b1, "R7");
        send(3'd3, 16'h002B, 2'd3, 1'b0, 16'h00FF, 1'b1, 4'hE, 2'd1, 1'b1, "R7");
        send(3'd4, 16'h002B, 2'd3, 1'b0, 16'h00FF, 1'b1, 4'hA, 2'd1, 1'b1, "R7");
        send(3'd4, 16'h0028, 2'd0, 1'b0, 16'h00FF, 1'b0, 4'h2, 2'd0, 1'b1, "R7");
        // R8 and R11 on data registers
        send(3'd1, 16'h0030, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b0, "R8");
        send(3'd2, 16'h0030, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'hA, 2'd0, 1'b0, "R8");
        send(3'd1, 16'h0030, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h8, 2'd0, 1'b0, "R11");
        idle("R2");
        // R9: limit boundary
        send(3'd1, 16'h0018, 2'd0, 1'b0, 16'h001F, 1'b1, 4'h2, 2'd0, 1'b1, "R9");
        send(3'd1, 16'h0020, 2'd0, 1'b0, 16'h001F, 1'b1, 4'h2, 2'd0, 1'b1, "R9");
        send(3'd0, 16'h0020, 2'd0, 1'b0, 16'h0026, 1'b1, 4'h2, 2'd0, 1'b0, "R9");
        send(3'd0, 16'hFFF8, 2'd0, 1'b0, 16'hFFFF, 1'b1, 4'h2, 2'd0, 1'b1, "R9");
        send(3'd3, 16'h0024, 2'd0, 1'b0, 16'h002F, 1'b1, 4'h2, 2'd0, 1'b1, "R9");
        // R10: 64-bit mode
        send(3'd0, 16'h0010, 2'd0, 1'b1, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b1, "R10");
        send(3'd1, 16'h0000, 2'd0, 1'b1, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b1, "R10");
        send(3'd2, 16'h0010, 2'd0, 1'b1, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b1, "R10");
        send(3'd3, 16'h0010, 2'd0, 1'b1, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b1, "R10");
        send(3'd4, 16'h0010, 2'd0, 1'b1, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b0, "R10");
        // R12: unused target codes
        send(3'd5, 16'h0010, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b1, "R12");
        send(3'd7, 16'h0000, 2'd0, 1'b0, 16'h00FF, 1'b1, 4'h2, 2'd0, 1'b1, "R12");
        idle("R2");
        idle("R2");
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule